// File: doc/BRIEF.md
# Two-Level Multi-CPU Interrupt Controller

This block collects level-sensitive interrupt sources and drives one interrupt line to each CPU of a small multiprocessor. Each source has to pass two gates before it reaches a CPU. The first gate is a single enable bit per source, which all CPUs share. The second gate is a per-CPU mask bit. Shared sources also need a routing bit that names the CPUs allowed to see them. The lowest-numbered sources are private: every CPU has its own physical line for each of these numbers, and the routing field has no effect on them.

Software controls the block through a simple register port. Each request carries the ID of the CPU making the access, and that ID chooses the mask bank for mask writes and for the pending-source query. To set or clear an enable or a mask bit, software writes the source number to a dedicated register. Reading the per-CPU acknowledge register returns the lowest-numbered source that is pending for that CPU. The port has no back-pressure. A request is taken on any cycle where `req_valid` is high. A read answers exactly one cycle later with `rsp_valid` high for one cycle, and a write produces no response.

Top module: `irq_fabric`

## Requirements
- R1: After reset every shared enable is 0, every per-CPU mask bit is 1 (masked), and every routing field reads 0. As a result `irq_out` is 0 and the acknowledge register returns 1023 for every CPU.
- R2: Writing source number n to byte address 0x030 sets the shared enable of n. Writing n to 0x034 clears it. A source whose enable is clear never reaches any CPU.
- R3: Writing n to 0x048 masks source n for the requesting CPU only, and writing n to 0x04C unmasks it for that CPU only.
- R4: The routing register of source n is at 0x100 + 4·n. Bits [3:0] hold one IRQ route bit per CPU (bit c is CPU c) and bits [11:8] hold the matching FIQ route bits. Both fields read back as written. A shared source reaches CPU c only when its bit c in [3:0] is set.
- R5: A read of address 0x000 returns the number of implemented sources in bits [11:2], with all other bits 0 (256 for 64 sources).
- R6: A read of address 0x044 returns, in bits [9:0], the lowest-numbered source that qualifies for the requesting CPU. When no source qualifies it returns 1023.
- R7: Sources are level sensitive. An acknowledge read does not clear anything: repeated reads return the same number while the level is held, and the result changes as soon as the level drops.
- R8: Sources 0 to 28 are private. CPU c uses its own line `priv_src[c*29+n]` for source n, ignores the routing field, and still obeys the shared enable and its own mask. Source s ≥ 29 uses `shared_src[s-29]`.
- R9: `irq_out[c]` is registered. It is high one cycle after some source is level-active, enabled, unmasked for CPU c and routed to CPU c (or private). It falls one cycle after the last such source stops qualifying.
- R10: A write of a source number of 64 or above to 0x030, 0x034, 0x048 or 0x04C has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| priv_src | input | 116 | Private levels, 29 per CPU, CPU c at [c*29 +: 29] |
| shared_src | input | 35 | Shared levels, bit k is source 29+k |
| req_valid | input | 1 | Register request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cpu | input | 2 | ID of the requesting CPU |
| req_addr | input | 12 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_data | output | 32 | Read data |
| irq_out | output | 4 | Interrupt line per CPU |

## Verification
Three latencies are in play. A register write changes the controller's state at the clock edge that samples it, so `irq_out` shows the effect one edge later. A change in a source level shows on `irq_out` after one edge. A read result arrives one cycle after the request and reflects the state and levels present at the sampling edge. The bench pushes each expected read value into a queue when it issues the read, and a monitor pops that value when `rsp_valid` rises at the following falling edge. Checks on `irq_out` wait one full cycle after a write task ends. The fall time is checked on both sides: the line is still high just after the level drops, and it is low one cycle later.

// File: rtl/irq_fabric_pkg.sv
package irq_fabric_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int SRC_W  = 10;

  localparam logic [ADDR_W-1:0] OFS_INFO    = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_EN_ON   = 12'h030;
  localparam logic [ADDR_W-1:0] OFS_EN_OFF  = 12'h034;
  localparam logic [ADDR_W-1:0] OFS_TAKE    = 12'h044;
  localparam logic [ADDR_W-1:0] OFS_MSK_ON  = 12'h048;
  localparam logic [ADDR_W-1:0] OFS_MSK_OFF = 12'h04C;
  localparam logic [ADDR_W-1:0] OFS_ROUTE   = 12'h100;

  localparam logic [SRC_W-1:0] IDLE_CODE = 10'd1023;
  localparam int FIQ_LSB = 8;
endpackage

// File: rtl/irq_fabric_lowest.sv
module irq_fabric_lowest #(
  parameter int N = 64,
  parameter int W = 10
) (
  input  logic [N-1:0] vec,
  output logic         found,
  output logic [W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int s = N - 1; s >= 0; s--) begin
      if (vec[s]) begin
        found = 1'b1;
        idx   = W'(s);
      end
    end
  end
endmodule

// File: rtl/irq_fabric_regs.sv
module irq_fabric_regs
  import irq_fabric_pkg::*;
#(
  parameter int NCPU  = 4,
  parameter int NSRC  = 64,
  parameter int CPU_W = 2,
  parameter int IDX_W = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  input  logic                          req_write,
  input  logic [CPU_W-1:0]              req_cpu,
  input  logic [ADDR_W-1:0]             req_addr,
  input  logic [DATA_W-1:0]             req_wdata,
  output logic [NSRC-1:0]               en_q,
  output logic [NCPU-1:0][NSRC-1:0]     mask_q,
  output logic [NSRC-1:0][NCPU-1:0]     rt_irq_q,
  output logic                          route_hit,
  output logic [DATA_W-1:0]             route_word
);
  logic [NSRC-1:0][NCPU-1:0] rt_fiq_q;
  logic [ADDR_W-1:0]         rt_off;
  logic [IDX_W-1:0]          rt_idx;
  logic [IDX_W-1:0]          num;
  logic                      num_ok;
  logic                      wr;

  assign wr     = req_valid && req_write;
  assign num    = req_wdata[IDX_W-1:0];
  assign num_ok = req_wdata < DATA_W'(NSRC);

  assign rt_off    = req_addr - OFS_ROUTE;
  assign rt_idx    = rt_off[IDX_W+1:2];
  assign route_hit = (req_addr >= OFS_ROUTE) && (rt_off[1:0] == 2'b00) &&
                     (32'(rt_off[ADDR_W-1:2]) < 32'(NSRC));
  assign route_word = DATA_W'(rt_irq_q[rt_idx]) |
                      (DATA_W'(rt_fiq_q[rt_idx]) << FIQ_LSB);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= '0;
      mask_q   <= '1;
      rt_irq_q <= '0;
      rt_fiq_q <= '0;
    end else if (wr) begin
      if (num_ok) begin
        case (req_addr)
          OFS_EN_ON:   en_q[num] <= 1'b1;
          OFS_EN_OFF:  en_q[num] <= 1'b0;
          OFS_MSK_ON:  mask_q[req_cpu][num] <= 1'b1;
          OFS_MSK_OFF: mask_q[req_cpu][num] <= 1'b0;
          default: ;
        endcase
      end
      if (route_hit) begin
        rt_irq_q[rt_idx] <= req_wdata[NCPU-1:0];
        rt_fiq_q[rt_idx] <= req_wdata[FIQ_LSB +: NCPU];
      end
    end
  end
endmodule

// File: rtl/irq_fabric_select.sv
module irq_fabric_select
  import irq_fabric_pkg::*;
#(
  parameter int NCPU  = 4,
  parameter int NSRC  = 64,
  parameter int NPRIV = 29,
  parameter int CPU   = 0
) (
  input  logic [NPRIV-1:0]           priv_lvl,
  input  logic [NSRC-NPRIV-1:0]      shared_lvl,
  input  logic [NSRC-1:0]            en,
  input  logic [NSRC-1:0]            mask_row,
  input  logic [NSRC-1:0][NCPU-1:0]  rt_irq,
  output logic                       any,
  output logic [SRC_W-1:0]           num
);
  logic [NSRC-1:0] qual;
  logic            found;
  logic [SRC_W-1:0] idx;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    if (s < NPRIV) begin : g_priv
      assign qual[s] = priv_lvl[s] & en[s] & ~mask_row[s];
    end else begin : g_shared
      assign qual[s] = shared_lvl[s-NPRIV] & en[s] & ~mask_row[s] & rt_irq[s][CPU];
    end
  end

  irq_fabric_lowest #(.N(NSRC), .W(SRC_W)) u_lowest (
    .vec   (qual),
    .found (found),
    .idx   (idx)
  );

  assign any = found;
  assign num = found ? idx : IDLE_CODE;
endmodule

// File: rtl/irq_fabric.sv
module irq_fabric
  import irq_fabric_pkg::*;
#(
  parameter int NCPU  = 4,
  parameter int NSRC  = 64,
  parameter int NPRIV = 29,
  localparam int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1,
  localparam int IDX_W = $clog2(NSRC)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NCPU*NPRIV-1:0]   priv_src,
  input  logic [NSRC-NPRIV-1:0]   shared_src,
  input  logic                    req_valid,
  input  logic                    req_write,
  input  logic [CPU_W-1:0]        req_cpu,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [DATA_W-1:0]       req_wdata,
  output logic                    rsp_valid,
  output logic [DATA_W-1:0]       rsp_data,
  output logic [NCPU-1:0]         irq_out
);
  logic [NSRC-1:0]               en_vec;
  logic [NCPU-1:0][NSRC-1:0]     mask_arr;
  logic [NSRC-1:0][NCPU-1:0]     rt_irq;
  logic                          route_hit;
  logic [DATA_W-1:0]             route_word;
  logic [NCPU-1:0]               any_vec;
  logic [NCPU-1:0][SRC_W-1:0]    ack_num;

  irq_fabric_regs #(
    .NCPU(NCPU), .NSRC(NSRC), .CPU_W(CPU_W), .IDX_W(IDX_W)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_cpu    (req_cpu),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .en_q       (en_vec),
    .mask_q     (mask_arr),
    .rt_irq_q   (rt_irq),
    .route_hit  (route_hit),
    .route_word (route_word)
  );

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    irq_fabric_select #(
      .NCPU(NCPU), .NSRC(NSRC), .NPRIV(NPRIV), .CPU(c)
    ) u_sel (
      .priv_lvl   (priv_src[c*NPRIV +: NPRIV]),
      .shared_lvl (shared_src),
      .en         (en_vec),
      .mask_row   (mask_arr[c]),
      .rt_irq     (rt_irq),
      .any        (any_vec[c]),
      .num        (ack_num[c])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_out   <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      irq_out   <= any_vec;
      rsp_valid <= req_valid && !req_write;
      if (req_valid && !req_write) begin
        if (route_hit) begin
          rsp_data <= route_word;
        end else begin
          case (req_addr)
            OFS_INFO: rsp_data <= DATA_W'(NSRC) << 2;
            OFS_TAKE: rsp_data <= DATA_W'(ack_num[req_cpu]);
            default:  rsp_data <= '0;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/irq_fabric_checker.sv
module irq_fabric_checker
  import irq_fabric_pkg::*;
#(
  parameter int NCPU = 4,
  parameter int NSRC = 64
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      req_valid,
  input logic                      req_write,
  input logic [ADDR_W-1:0]         req_addr,
  input logic                      rsp_valid,
  input logic [DATA_W-1:0]         rsp_data,
  input logic [NCPU-1:0]           irq_out,
  input logic [NSRC-1:0]           en_vec,
  input logic [NCPU-1:0][NSRC-1:0] mask_arr,
  input logic [NCPU-1:0]           any_vec
);
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> irq_out == '0);

  a_r9_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq_out == $past(any_vec));

  a_r2_no_enable_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    en_vec == '0 |=> irq_out == '0);

  for (genvar c = 0; c < NCPU; c++) begin : g_m
    a_r3_all_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (&mask_arr[c]) |=> !irq_out[c]);
  end

  a_r6_ack_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(req_valid) && !$past(req_write) && $past(req_addr) == OFS_TAKE)
    |-> (32'(rsp_data[SRC_W-1:0]) < 32'(NSRC) || rsp_data[SRC_W-1:0] == IDLE_CODE));

  a_r5_info_word: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(req_valid) && !$past(req_write) && $past(req_addr) == OFS_INFO)
    |-> rsp_data == (DATA_W'(NSRC) << 2));
endmodule

bind irq_fabric irq_fabric_checker #(.NCPU(NCPU), .NSRC(NSRC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_addr  (req_addr),
  .rsp_valid (rsp_valid),
  .rsp_data  (rsp_data),
  .irq_out   (irq_out),
  .en_vec    (en_vec),
  .mask_arr  (mask_arr),
  .any_vec   (any_vec)
);

// File: tb/irq_fabric_bench.sv
`timescale 1ns/1ps
module irq_fabric_bench;
  localparam int NCPU = 4;
  localparam int NSRC = 64;
  localparam int NPRIV = 29;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCPU*NPRIV-1:0] priv_src = '0;
  logic [NSRC-NPRIV-1:0] shared_src = '0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [1:0] req_cpu = '0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_valid;
  logic [31:0] rsp_data;
  logic [NCPU-1:0] irq_out;

  int checks = 0;
  int failures = 0;
  int exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  irq_fabric u_irq_fabric (
    .clk(clk), .rst_n(rst_n), .priv_src(priv_src), .shared_src(shared_src),
    .req_valid(req_valid), .req_write(req_write), .req_cpu(req_cpu),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .irq_out(irq_out)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int cpu, input int addr, input int data);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_cpu = cpu[1:0];
    req_addr = addr[11:0]; req_wdata = data;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input int cpu, input int addr, input int exp, input string tag);
    @(negedge clk);
    exp_q.push_back(exp); tag_q.push_back(tag);
    req_valid = 1'b1; req_write = 1'b0; req_cpu = cpu[1:0];
    req_addr = addr[11:0];
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic irq_is(input int exp, input string tag);
    chk(tag, int'(irq_out), exp);
  endtask

  // Scoreboard monitor: one response per queued expectation
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        chk("unexpected response", 1, 0);
      end else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, int'(rsp_data), e);
      end
    end
  end

  initial begin
    #240000;
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    shared_src[11] = 1'b1;                 // source 40 level high during reset
    idle(3);
    rst_n = 1'b1;
    idle(1);
    irq_is(0, "R1 irq after reset");
    rd(0, 'h000, 256, "R5 info word");
    for (int c = 0; c < NCPU; c++) rd(c, 'h044, 1023, "R1 ack idle after reset");
    rd(0, 'h1A0, 0, "R1 route cleared");

    wr(0, 'h030, 40); idle(1);
    irq_is(0, "R3 masked by default");
    wr(1, 'h04C, 40); idle(1);
    irq_is(0, "R4 unrouted shared source");
    wr(0, 'h1A0, 'h302); idle(1);
    irq_is('b0010, "R4 routed to cpu1");
    rd(0, 'h1A0, 'h302, "R4 route readback");
    rd(1, 'h044, 40, "R6 ack cpu1");
    rd(1, 'h044, 40, "R7 ack repeat");
    rd(0, 'h044, 1023, "R3 cpu0 still masked");

    wr(0, 'h1A0, 'h003); idle(1);
    irq_is('b0010, "R3 route but masked cpu0");
    wr(0, 'h04C, 40); idle(1);
    irq_is('b0011, "R3 unmask cpu0");
    wr(1, 'h048, 40); idle(1);
    irq_is('b0001, "R3 mask cpu1 only");

    wr(2, 'h034, 40); idle(1);
    irq_is(0, "R2 enable cleared");
    wr(3, 'h030, 40); idle(1);
    irq_is('b0001, "R2 enable set again");

    @(negedge clk) priv_src[2*NPRIV+5] = 1'b1;
    wr(0, 'h030, 5);
    wr(2, 'h04C, 5);
    wr(3, 'h04C, 5); idle(1);
    irq_is('b0101, "R8 private line cpu2 only");
    rd(2, 'h044, 5, "R8 ack private");
    rd(3, 'h044, 1023, "R8 other cpu line low");

    @(negedge clk) shared_src[4] = 1'b1;   // source 33
    wr(0, 'h030, 33);
    wr(0, 'h04C, 33);
    wr(0, 'h184, 1);
    rd(0, 'h044, 33, "R6 lowest wins");
    @(negedge clk) shared_src[4] = 1'b0;
    rd(0, 'h044, 40, "R7 level drop changes ack");

    wr(0, 'h034, 40); idle(1);
    irq_is('b0100, "R2 cpu0 quiet");
    @(negedge clk) priv_src[0] = 1'b1;
    wr(0, 'h04C, 0); idle(1);
    irq_is('b0100, "R2 private src0 not enabled");
    wr(0, 'h030, 64); idle(1);
    irq_is('b0100, "R10 out-of-range enable ignored");
    rd(0, 'h044, 1023, "R10 ack unchanged");
    wr(2, 'h048, 69); idle(1);
    irq_is('b0100, "R10 out-of-range mask ignored");
    wr(0, 'h030, 0); idle(1);
    irq_is('b0101, "R10 in-range enable works");
    rd(0, 'h044, 0, "R6 source zero");

    @(negedge clk) priv_src[0] = 1'b0;
    #1 chk("R9 still high before edge", int'(irq_out[0]), 1);
    @(negedge clk);
    irq_is('b0100, "R9 falls after one edge");

    idle(3);
    chk("R6 all responses seen", exp_q.size(), 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule